// File: doc/BRIEF.md
# Memory Card Sector Responder

This block is the device end of a byte-exchange link for a small removable storage card. For every byte the host shifts in, the block returns one reply byte on the following clock, and it marks the reply that closes a frame. A frame opens with a select byte and a command letter. It then runs through a fixed sequence of handshake, address, data, checksum and status positions. The card holds up to 1024 sectors of 128 bytes. Three commands are understood: read a sector, write a sector, and report the card's identity.

Sector addresses are 16 bits wide. Any address with a bit set above bit 9 marks the frame as failed. A failed read stops early. A failed write still runs to its end, but nothing is stored and the frame closes with a failure code. Each read or write is protected by an XOR checksum over the two address bytes and the 128 data bytes. A one-bit "fresh card" flag is reported in the command position: it reads as set after power-up and stays cleared once any write has delivered its first data byte. The sector store can be made shallower than 1024 sectors by parameter. Address checking always uses 10 bits, and shallower stores alias on the low address bits.

Top module: `mc_responder`

## Requirements
- R1: While reset is held and directly after it, `dev_valid` and `dev_last` are 0 and `dev_byte` is 0xFF.
- R2: With no frame open, host byte 0x81 is answered with 0x00 (not final) and opens a frame. Any other byte is answered with 0xFF marked final, and no frame opens.
- R3: The command position (0x52 read, 0x57 write, 0x53 identify) is answered with 0x08 from reset until the first data byte of any write. After that it is answered with 0x00.
- R4: The two positions after the command reply 0x5A then 0x5D. For any other command letter, the first of them replies 0xFF marked final and the frame closes.
- R5: In the address positions, and in the data and checksum positions of a write, each reply is the host byte of the previous position. The first address reply is 0x00.
- R6: A read with a valid address continues with 0x5C, 0x5D, the address MSB, the address LSB, 128 data bytes, the checksum, and then 0x47 marked final.
- R7: The read checksum is the XOR of the address MSB, the address LSB and the 128 data bytes returned.
- R8: A read whose address has any of bits 15..10 set replies 0x5C, 0x5D, then 0xFF, then 0xFF marked final.
- R9: A write with a valid address stores data byte k at byte k of the addressed sector, and a later read returns it.
- R10: A write closes with 0x5C, 0x5D and a final status byte. The status is 0x47 when the host checksum matches and 0x4E when it does not. For an out-of-range address the status is 0xFF and the sector store is left unchanged.
- R11: Identify replies 0x5A, 0x5D, 0x5C, 0x5D, 0x04, 0x00, 0x00, 0x80, and the last of these is marked final.
- R12: After reset, sector 0 holds 0x4D at byte 0, 0x43 at byte 1, 0x0E at byte 127 and zero elsewhere. All other sectors are zero.
- R13: `dev_valid` is high in exactly the cycle after each `host_valid` strobe, and `dev_last` is only ever high together with `dev_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | One-cycle strobe: a host byte is present |
| host_byte | input | 8 | Byte received from the host |
| dev_valid | output | 1 | Reply present, one cycle after the strobe |
| dev_byte | output | 8 | Reply byte; holds its value between strobes |
| dev_last | output | 1 | Reply closes the frame |

## Verification
The checker counts frame positions from the outside. It assumes that every host strobe belongs to the frame that the block sees, so that positions 1 and 2 after an opening byte are the command and the first ID reply. It also assumes that no strobe arrives before reset has been released. The bench strobes only every other cycle and always opens a frame with 0x81 before sending a command. It sends zeros in positions where the host has no data, so the position count the checker keeps matches the count the block keeps.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam logic [7:0] OPEN_BYTE   = 8'h81;
    localparam logic [7:0] LETTER_RD   = 8'h52;
    localparam logic [7:0] LETTER_WR   = 8'h57;
    localparam logic [7:0] LETTER_ID   = 8'h53;
    localparam logic [7:0] STAT_GOOD   = 8'h47;
    localparam logic [7:0] STAT_BADSUM = 8'h4E;
    localparam logic [7:0] STAT_POISON = 8'hFF;
    localparam int         SECT_BYTES  = 128;
    localparam int         IDX_W       = $clog2(SECT_BYTES);
    localparam int         CHECK_BITS  = 10;

    typedef enum logic [4:0] {
        ST_IDLE, ST_CMD, ST_ID1, ST_ID2, ST_AMSB, ST_ALSB,
        ST_ACK1, ST_ACK2, ST_CMSB, ST_CLSB, ST_DATA, ST_CSUM,
        ST_END, ST_IDE1, ST_IDE2, ST_IDE3, ST_IDE4
    } stage_t;

    typedef enum logic [1:0] {
        OP_READ, OP_WRITE, OP_IDENT, OP_BAD
    } op_t;

    typedef struct packed {
        stage_t           stage;
        op_t              op;
        logic             fresh;
        logic [15:0]      addr;
        logic [IDX_W-1:0] idx;
        logic [7:0]       csum;
        logic [7:0]       status;
        logic [7:0]       prev;
        logic [7:0]       reply;
        logic             valid;
        logic             last;
    } eng_t;

endpackage

// File: rtl/mc_sector_ram.sv
module mc_sector_ram #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    function automatic logic [7:0] blank_byte(input int i);
        case (i)
            0:       return 8'h4D;
            1:       return 8'h43;
            127:     return 8'h0E;
            default: return 8'h00;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= blank_byte(i);
            end
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/mc_cmd_engine.sv
module mc_cmd_engine
    import mc_pkg::*;
#(
    parameter int SECT_LOG2 = 3,
    localparam int AW = SECT_LOG2 + IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_valid,
    input  logic [7:0]    host_byte,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] ram_addr,
    output logic          wr_en,
    output logic [7:0]    wr_data,
    output logic          dev_valid,
    output logic [7:0]    dev_byte,
    output logic          dev_last
);
    eng_t q, d;

    assign ram_addr  = {q.addr[SECT_LOG2-1:0], q.idx};
    assign wr_data   = host_byte;
    assign dev_valid = q.valid;
    assign dev_byte  = q.reply;
    assign dev_last  = q.last;

    always_comb begin
        d       = q;
        d.valid = host_valid;
        d.last  = 1'b0;
        wr_en   = 1'b0;
        if (host_valid) begin
            case (q.stage)
                ST_IDLE: begin
                    if (host_byte == OPEN_BYTE) begin
                        d.reply  = 8'h00;
                        d.stage  = ST_CMD;
                        d.addr   = '0;
                        d.idx    = '0;
                        d.csum   = '0;
                        d.status = '0;
                        d.prev   = '0;
                    end else begin
                        d.reply = 8'hFF;
                        d.last  = 1'b1;
                    end
                end
                ST_CMD: begin
                    case (host_byte)
                        LETTER_RD: d.op = OP_READ;
                        LETTER_WR: d.op = OP_WRITE;
                        LETTER_ID: d.op = OP_IDENT;
                        default:   d.op = OP_BAD;
                    endcase
                    d.reply = q.fresh ? 8'h08 : 8'h00;
                    d.stage = ST_ID1;
                end
                ST_ID1: begin
                    if (q.op == OP_BAD) begin
                        d.reply = 8'hFF;
                        d.last  = 1'b1;
                        d.stage = ST_IDLE;
                    end else begin
                        d.reply = 8'h5A;
                        d.stage = ST_ID2;
                    end
                end
                ST_ID2: begin
                    d.reply = 8'h5D;
                    d.stage = (q.op == OP_IDENT) ? ST_ACK1 : ST_AMSB;
                end
                ST_AMSB: begin
                    d.reply      = q.prev;
                    d.prev       = host_byte;
                    d.csum       = host_byte;
                    d.addr[15:8] = host_byte;
                    d.stage      = ST_ALSB;
                end
                ST_ALSB: begin
                    d.reply     = q.prev;
                    d.prev      = host_byte;
                    d.csum      = q.csum ^ host_byte;
                    d.addr[7:0] = host_byte;
                    if (q.addr[15:CHECK_BITS] != '0) begin
                        d.status = STAT_POISON;
                    end
                    d.stage = (q.op == OP_READ) ? ST_ACK1 : ST_DATA;
                end
                ST_ACK1: begin
                    d.reply = 8'h5C;
                    d.stage = ST_ACK2;
                end
                ST_ACK2: begin
                    d.reply = 8'h5D;
                    case (q.op)
                        OP_READ:  d.stage = ST_CMSB;
                        OP_WRITE: d.stage = ST_END;
                        default:  d.stage = ST_IDE1;
                    endcase
                end
                ST_CMSB: begin
                    d.reply = (q.status == STAT_POISON) ? 8'hFF : q.addr[15:8];
                    d.stage = ST_CLSB;
                end
                ST_CLSB: begin
                    if (q.status == STAT_POISON) begin
                        d.reply = 8'hFF;
                        d.last  = 1'b1;
                        d.stage = ST_IDLE;
                    end else begin
                        d.reply = q.addr[7:0];
                        d.stage = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (q.op == OP_READ) begin
                        d.reply = rd_data;
                        d.csum  = q.csum ^ rd_data;
                    end else begin
                        if (q.idx == '0) begin
                            d.fresh = 1'b0;
                        end
                        if (q.status != STAT_POISON) begin
                            wr_en  = 1'b1;
                            d.csum = q.csum ^ host_byte;
                        end
                        d.reply = q.prev;
                        d.prev  = host_byte;
                    end
                    d.idx = q.idx + 1'b1;
                    if (q.idx == IDX_W'(SECT_BYTES - 1)) begin
                        d.stage = ST_CSUM;
                    end
                end
                ST_CSUM: begin
                    if (q.op == OP_READ) begin
                        d.reply  = q.csum;
                        d.status = STAT_GOOD;
                        d.stage  = ST_END;
                    end else begin
                        if (q.status == 8'h00) begin
                            d.status = (q.csum == host_byte) ? STAT_GOOD : STAT_BADSUM;
                        end else begin
                            d.status = STAT_POISON;
                        end
                        d.reply = q.prev;
                        d.prev  = host_byte;
                        d.stage = ST_ACK1;
                    end
                end
                ST_END: begin
                    d.reply = q.status | 8'h04;
                    d.last  = 1'b1;
                    d.stage = ST_IDLE;
                end
                ST_IDE1: begin
                    d.reply = 8'h04;
                    d.stage = ST_IDE2;
                end
                ST_IDE2: begin
                    d.reply = 8'h00;
                    d.stage = ST_IDE3;
                end
                ST_IDE3: begin
                    d.reply = 8'h00;
                    d.stage = ST_IDE4;
                end
                ST_IDE4: begin
                    d.reply = 8'h80;
                    d.last  = 1'b1;
                    d.stage = ST_IDLE;
                end
                default: begin
                    d.reply = 8'hFF;
                    d.last  = 1'b1;
                    d.stage = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.stage  <= ST_IDLE;
            q.op     <= OP_READ;
            q.fresh  <= 1'b1;
            q.reply  <= 8'hFF;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/mc_responder.sv
module mc_responder #(
    parameter int SECT_LOG2 = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_valid,
    input  logic [7:0] host_byte,
    output logic       dev_valid,
    output logic [7:0] dev_byte,
    output logic       dev_last
);
    localparam int AW = SECT_LOG2 + mc_pkg::IDX_W;

    logic [AW-1:0] ram_addr;
    logic          wr_en;
    logic [7:0]    wr_data;
    logic [7:0]    rd_data;

    mc_cmd_engine #(.SECT_LOG2(SECT_LOG2)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_valid (host_valid),
        .host_byte  (host_byte),
        .rd_data    (rd_data),
        .ram_addr   (ram_addr),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .dev_valid  (dev_valid),
        .dev_byte   (dev_byte),
        .dev_last   (dev_last)
    );

    mc_sector_ram #(.AW(AW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .addr  (ram_addr),
        .wdata (wr_data),
        .rdata (rd_data)
    );

endmodule

// File: rtl/mc_responder_chk.sv
module mc_responder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_valid,
    input logic [7:0] host_byte,
    input logic       dev_valid,
    input logic [7:0] dev_byte,
    input logic       dev_last
);
    logic       busy_q;
    logic [8:0] pos_q;
    logic       cmd_pend_q;
    logic       cleared_q;
    logic       idle_now;

    assign idle_now = !busy_q || dev_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            pos_q      <= '0;
            cmd_pend_q <= 1'b0;
            cleared_q  <= 1'b0;
        end else begin
            if (host_valid) begin
                if (idle_now) begin
                    busy_q <= (host_byte == 8'h81);
                    pos_q  <= 9'd1;
                end else if (pos_q != 9'h1FF) begin
                    pos_q <= pos_q + 9'd1;
                end
            end else if (dev_last) begin
                busy_q <= 1'b0;
            end
            cmd_pend_q <= host_valid && !idle_now && (pos_q == 9'd1);
            if (cmd_pend_q && dev_byte == 8'h00) begin
                cleared_q <= 1'b1;
            end
        end
    end

    AST_VALID_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid |=> dev_valid); // R13
    AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !host_valid |=> !dev_valid); // R13
    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        dev_last |-> dev_valid); // R13
    AST_OPEN_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && idle_now && host_byte == 8'h81) |=> (dev_byte == 8'h00 && !dev_last)); // R2
    AST_STRAY_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && idle_now && host_byte != 8'h81) |=> (dev_byte == 8'hFF && dev_last)); // R2
    AST_FLAG_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !idle_now && pos_q == 9'd1) |=> (dev_byte == 8'h08 || dev_byte == 8'h00)); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !idle_now && pos_q == 9'd1 && cleared_q) |=> (dev_byte == 8'h00)); // R3
    AST_ID_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !idle_now && pos_q == 9'd2) |=> (dev_byte == 8'h5A || (dev_byte == 8'hFF && dev_last))); // R4
    AST_END_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        dev_last |-> (dev_byte inside {8'hFF, 8'h47, 8'h4E, 8'h80})); // R10

endmodule

bind mc_responder mc_responder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_valid (host_valid),
    .host_byte  (host_byte),
    .dev_valid  (dev_valid),
    .dev_byte   (dev_byte),
    .dev_last   (dev_last)
);

// File: tb/sim_mc_responder.sv
`timescale 1ns/1ps
module sim_mc_responder;
    localparam int SW = 3;
    localparam int NV = 14;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_valid;
    logic [7:0] host_byte;
    logic       dev_valid;
    logic [7:0] dev_byte;
    logic       dev_last;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [7:0] model [1024];

    always #2 clk = ~clk;

    mc_responder #(.SECT_LOG2(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_byte(host_byte),
        .dev_valid(dev_valid), .dev_byte(dev_byte), .dev_last(dev_last)
    );

    // {host byte, expected reply, expected last, requirement code}
    localparam logic [20:0] VEC [NV] = '{
        {8'h00, 8'hFF, 1'b1, 4'd2},
        {8'h81, 8'h00, 1'b0, 4'd2},
        {8'h53, 8'h08, 1'b0, 4'd3},
        {8'h00, 8'h5A, 1'b0, 4'd11},
        {8'h00, 8'h5D, 1'b0, 4'd11},
        {8'h00, 8'h5C, 1'b0, 4'd11},
        {8'h00, 8'h5D, 1'b0, 4'd11},
        {8'h00, 8'h04, 1'b0, 4'd11},
        {8'h00, 8'h00, 1'b0, 4'd11},
        {8'h00, 8'h00, 1'b0, 4'd11},
        {8'h00, 8'h80, 1'b1, 4'd11},
        {8'h81, 8'h00, 1'b0, 4'd2},
        {8'h58, 8'h08, 1'b0, 4'd3},
        {8'h00, 8'hFF, 1'b1, 4'd4}
    };

    function automatic string req_name(input logic [3:0] c);
        case (c)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %03h expected %03h", req, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] b, input logic [7:0] exp, input logic exp_last,
                        input string req);
        logic [7:0] r;
        logic       l;
        logic       v;
        @(negedge clk);
        host_valid = 1'b1;
        host_byte  = b;
        @(negedge clk);
        host_valid = 1'b0;
        r = dev_byte;
        l = dev_last;
        v = dev_valid;
        chk(v && r == exp && l == exp_last, req, {v, l, r}, {1'b1, exp_last, exp});
    endtask

    task automatic do_read(input logic [15:0] a, input logic [7:0] flag, input string dreq);
        logic [7:0] cs;
        logic [7:0] e;
        step(8'h81, 8'h00, 1'b0, "R2");
        step(8'h52, flag, 1'b0, "R3");
        step(8'h00, 8'h5A, 1'b0, "R4");
        step(8'h00, 8'h5D, 1'b0, "R4");
        step(a[15:8], 8'h00, 1'b0, "R5");
        step(a[7:0], a[15:8], 1'b0, "R5");
        step(8'h00, 8'h5C, 1'b0, "R6");
        step(8'h00, 8'h5D, 1'b0, "R6");
        if (a[15:10] != 6'd0) begin
            step(8'h00, 8'hFF, 1'b0, "R8");
            step(8'h00, 8'hFF, 1'b1, "R8");
        end else begin
            step(8'h00, a[15:8], 1'b0, "R6");
            step(8'h00, a[7:0], 1'b0, "R6");
            cs = a[15:8] ^ a[7:0];
            for (int i = 0; i < 128; i++) begin
                e = model[{a[SW-1:0], 7'(i)}];
                step(8'h00, e, 1'b0, dreq);
                cs ^= e;
            end
            step(8'h00, cs, 1'b0, "R7");
            step(8'h00, 8'h47, 1'b1, "R6");
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] flag, input logic [7:0] seed,
                            input bit bad_sum);
        logic [7:0] dat [128];
        logic [7:0] cs;
        logic [7:0] endb;
        bit         poison;
        poison = (a[15:10] != 6'd0);
        cs = a[15:8] ^ a[7:0];
        for (int i = 0; i < 128; i++) begin
            dat[i] = seed + 8'(i * 7);
            cs ^= dat[i];
        end
        if (bad_sum) cs ^= 8'h01;
        step(8'h81, 8'h00, 1'b0, "R2");
        step(8'h57, flag, 1'b0, "R3");
        step(8'h00, 8'h5A, 1'b0, "R4");
        step(8'h00, 8'h5D, 1'b0, "R4");
        step(a[15:8], 8'h00, 1'b0, "R5");
        step(a[7:0], a[15:8], 1'b0, "R5");
        for (int i = 0; i < 128; i++) begin
            step(dat[i], (i == 0) ? a[7:0] : dat[i-1], 1'b0, "R5");
        end
        step(cs, dat[127], 1'b0, "R5");
        step(8'h00, 8'h5C, 1'b0, "R10");
        step(8'h00, 8'h5D, 1'b0, "R10");
        endb = poison ? 8'hFF : (bad_sum ? 8'h4E : 8'h47);
        step(8'h00, endb, 1'b1, "R10");
        if (!poison) begin
            for (int i = 0; i < 128; i++) model[{a[SW-1:0], 7'(i)}] = dat[i];
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) model[i] = 8'h00;
        model[0] = 8'h4D;
        model[1] = 8'h43;
        model[127] = 8'h0E;

        rst_n = 1'b0;
        host_valid = 1'b0;
        host_byte = 8'h00;
        repeat (3) @(negedge clk);
        chk(!dev_valid && !dev_last && dev_byte == 8'hFF, "R1", {dev_valid, dev_last, dev_byte}, 10'h0FF);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dev_valid && !dev_last && dev_byte == 8'hFF, "R1", {dev_valid, dev_last, dev_byte}, 10'h0FF);

        for (int k = 0; k < NV; k++) begin
            step(VEC[k][20:13], VEC[k][12:5], VEC[k][4], req_name(VEC[k][3:0]));
        end

        // R13: reply strobe lasts one cycle only
        @(negedge clk);
        chk(!dev_valid && !dev_last, "R13", {dev_valid, dev_last}, 0);

        do_read(16'h0000, 8'h08, "R12");
        do_read(16'h0800, 8'h08, "R8");
        do_write(16'h0005, 8'h08, 8'h01, 1'b0);
        do_read(16'h0005, 8'h00, "R9");
        do_write(16'h0006, 8'h00, 8'h30, 1'b1);
        do_write(16'h0405, 8'h00, 8'h99, 1'b0);
        do_read(16'h0005, 8'h00, "R10");
        step(8'h00, 8'hFF, 1'b1, "R2");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule